// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM read or write burst. A controller pulses a start strobe together with the first column, the burst length code and the ordering bit; from the next cycle the block presents one column per beat and moves to the next column each cycle the controller raises the advance input. A last-beat flag marks the final column of a fixed-length burst, so the command logic can plan the next access without counting beats itself.

Two orderings are supported. Linear ordering counts upward and wraps inside the block of columns aligned to the burst length. Interleaved ordering forms each beat by XOR of the starting low bits with the beat number. A full-page burst sweeps the whole row, wrapping from the top column to column 0, and runs until it is stopped or replaced. A stop input ends any burst at once. A new start strobe replaces whatever burst is in progress.

Top module: `burst_col_gen`

## Requirements
- R1: One cycle after a start strobe, beatValid is 1 and colOut equals the start column. The length code and ordering are captured at the strobe, and changes to them later in the burst have no effect. A start strobe during a burst restarts from the new column.
- R2: The 3-bit length code blSel selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Any code with bit 2 set gives a full page. A fixed burst ends after the advance that is taken on its last beat, so beatValid is 0 in the following cycle.
- R3: With typeIlv = 0, beat n has low log2(BL) bits equal to (start low bits + n) mod BL. All higher column bits equal those of the start column.
- R4: With typeIlv = 1 and a fixed length, beat n has low log2(BL) bits equal to (start low bits XOR n). All higher column bits equal those of the start column.
- R5: In a full-page burst, beat n has colOut = (start + n) mod 256, so column 255 is followed by column 0. The burst never raises lastBeat and continues until stop or a new start strobe.
- R6: A full-page code together with typeIlv = 1 produces the same linear sequence as a full-page code with typeIlv = 0.
- R7: lastBeat is 1 exactly when beatValid is 1, the burst has a fixed length, and the current beat is number BL-1. With a length of 1, lastBeat is 1 on the first beat.
- R8: stop during a burst makes beatValid 0 in the next cycle, whatever length is programmed. A start strobe in the same cycle wins over stop.
- R9: While advance is 0, colOut, beatValid and lastBeat hold their values.
- R10: After reset, beatValid = 0, lastBeat = 0 and colOut = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startStb | input | 1 | Begin a new burst at startCol |
| startCol | input | COL_W (8) | First column of the burst |
| blSel | input | 3 | Burst length code |
| typeIlv | input | 1 | 1 = interleaved ordering, 0 = linear |
| advance | input | 1 | Move to the next beat this cycle |
| stop | input | 1 | Terminate the burst |
| colOut | output | COL_W (8) | Column address of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench builds the block with its default 8-bit column, which gives a 256-column page. With that size a full-page burst can be run across the 255-to-0 wrap in a few cycles, and every fixed length up to 8 can be tried at start columns that sit off the aligned block boundary. These starts exercise linear wrap inside the block, the XOR ordering, and the rule that the upper bits do not move. Gaps in advance, mid-burst stop, restart during a burst, and changes to the length code after the strobe are mixed into the same runs.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int LEN_LOG_W = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } colStrb_t;

  // burst configuration captured at start
  typedef struct packed {
    logic                 full;
    logic                 ilv;
    logic [LEN_LOG_W-1:0] lenLog;
  } burstCfg_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic [2:0] blSel,
  input  logic      typeIlv,
  input  logic      advance,
  input  logic      stop,
  input  logic      atLast,
  output colStrb_t  strb,
  output burstCfg_t cfgQ,
  output logic      active,
  output logic      lastBeat
);

  logic selFull;
  logic endNow;

  assign selFull  = blSel[2];
  assign lastBeat = active & ~cfgQ.full & atLast;
  assign endNow   = active & (stop | (advance & lastBeat));

  assign strb.load = startStb;
  assign strb.step = active & advance & ~stop & ~startStb & ~lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cfgQ   <= '0;
    end else if (startStb) begin
      active      <= 1'b1;
      cfgQ.full   <= selFull;
      cfgQ.ilv    <= typeIlv & ~selFull;
      cfgQ.lenLog <= blSel[LEN_LOG_W-1:0];
    end else if (endNow) begin
      active <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrb_t         strb,
  input  burstCfg_t        cfgQ,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut,
  output logic             atLast
);

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] linCol;
  logic [COL_W-1:0] ilvCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (strb.load) begin
      baseQ <= startCol;
      beatQ <= '0;
    end else if (strb.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  assign linCol = baseQ + beatQ;
  assign ilvCol = baseQ ^ beatQ;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign mask[i]   = cfgQ.full | (i < int'(cfgQ.lenLog));
    assign colOut[i] = mask[i] ? (cfgQ.ilv ? ilvCol[i] : linCol[i]) : baseQ[i];
  end

  assign atLast = (beatQ == mask);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             typeIlv,
  input  logic             advance,
  input  logic             stop,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat
);

  colStrb_t  strb;
  burstCfg_t cfgQ;
  logic      atLast;
  logic      cfgFull;

  assign cfgFull = cfgQ.full;

  burst_col_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .blSel    (blSel),
    .typeIlv  (typeIlv),
    .advance  (advance),
    .stop     (stop),
    .atLast   (atLast),
    .strb     (strb),
    .cfgQ     (cfgQ),
    .active   (beatValid),
    .lastBeat (lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgQ     (cfgQ),
    .startCol (startCol),
    .colOut   (colOut),
    .atLast   (atLast)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       blSel,
  input logic             advance,
  input logic             stop,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat,
  input logic             cfgFull
);

  a_r1_first_col: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (beatValid && colOut == $past(startCol)));

  a_r2_burst_ends: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && lastBeat && advance && !stop && !startStb) |=> !beatValid);

  a_r5_full_step: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && cfgFull && advance && !stop && !startStb)
      |=> (colOut == COL_W'($past(colOut) + 1'b1)));

  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rstN)
    cfgFull |-> !lastBeat);

  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  a_r7_bl1_first: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && blSel == 3'd0) |=> lastBeat);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && stop && !startStb) |=> !beatValid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !advance && !stop && !startStb)
      |=> ($stable(colOut) && beatValid && $stable(lastBeat)));

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startStb  (startStb),
  .startCol  (startCol),
  .blSel     (blSel),
  .advance   (advance),
  .stop      (stop),
  .colOut    (colOut),
  .beatValid (beatValid),
  .lastBeat  (lastBeat),
  .cfgFull   (cfgFull)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  localparam int COL_W = 8;
  localparam int PAGE  = 256;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       blSel = '0;
  logic             typeIlv = 1'b0;
  logic             advance = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid;
  logic             lastBeat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int mActive = 0, mStart = 0, mN = 0, mBl = 1, mFull = 0, mIlv = 0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .blSel(blSel), .typeIlv(typeIlv), .advance(advance), .stop(stop),
    .colOut(colOut), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  function automatic int expCol();
    int lo;
    if (mFull != 0) return (mStart + mN) % PAGE;
    lo = mStart % mBl;
    if (mIlv != 0) return (mStart - lo) + (lo ^ mN);
    return (mStart - lo) + ((lo + mN) % mBl);
  endfunction

  task automatic compare(input string tag);
    int eCol;
    int eLast;
    eCol  = expCol();
    eLast = (mActive != 0 && mFull == 0 && mN == mBl - 1) ? 1 : 0;
    checks++;
    if (beatValid !== (mActive != 0) || lastBeat !== (eLast != 0) ||
        (mActive != 0 && colOut !== eCol[COL_W-1:0])) begin
      fails++;
      $display("FAIL %s: got valid=%0b last=%0b col=%0d, expected valid=%0d last=%0d col=%0d",
               tag, beatValid, lastBeat, colOut, mActive, eLast, eCol);
    end
  endtask

  // one clock: drive at negedge, update model at edge, compare at next negedge
  task automatic cyc(input bit st, input int col, input int sel, input bit ilv,
                     input bit adv, input bit stp, input string tag);
    startStb = st; startCol = col[COL_W-1:0]; blSel = sel[2:0];
    typeIlv = ilv; advance = adv; stop = stp;
    @(posedge clk);
    if (st) begin
      mActive = 1; mStart = col; mN = 0;
      mFull = (sel >= 4) ? 1 : 0;
      mBl = (mFull != 0) ? PAGE : (1 << sel);
      mIlv = (ilv && mFull == 0) ? 1 : 0;
    end else if (mActive != 0 && stp) begin
      mActive = 0;
    end else if (mActive != 0 && adv) begin
      if (mFull == 0 && mN == mBl - 1) mActive = 0;
      else mN = (mN + 1) % PAGE;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (beatValid !== 1'b0 || lastBeat !== 1'b0 || colOut !== '0) begin
      fails++;
      $display("FAIL R10: got valid=%0b last=%0b col=%0d, expected 0 0 0",
               beatValid, lastBeat, colOut);
    end
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R10");

    // R1 R3 linear BL4 off-aligned start, then end (R2)
    cyc(1, 8'h35, 2, 0, 0, 0, "R1");
    run(4, "R3");
    cyc(0, 0, 0, 0, 0, 0, "R2");

    // R3 linear BL8 with length code changed mid burst (R1 capture)
    cyc(1, 8'hAD, 3, 0, 1, 0, "R1");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 1, 0, "R3");
    // R4 interleaved BL8 with gaps (R9)
    cyc(1, 8'h2B, 3, 1, 0, 0, "R4");
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 0, 0, 0, "R9");
      cyc(0, 0, 0, 0, 1, 0, "R4");
    end
    // R4 interleaved BL4 and BL2
    cyc(1, 8'h66, 2, 1, 0, 0, "R4");
    run(4, "R4");
    cyc(1, 8'h13, 1, 1, 0, 0, "R4");
    run(2, "R4");
    cyc(1, 8'h13, 1, 0, 0, 0, "R3");
    run(2, "R3");
    // R7 BL1 last on first beat
    cyc(1, 8'h7F, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R7");
    run(1, "R7");
    // R5 full page across wrap
    cyc(1, 8'hFC, 4, 0, 0, 0, "R5");
    run(10, "R5");
    cyc(0, 0, 0, 0, 1, 1, "R8");
    // R6 full page with interleave requested
    cyc(1, 8'hFD, 7, 1, 1, 0, "R6");
    run(6, "R6");
    cyc(0, 0, 0, 0, 0, 1, "R8");
    // R8 stop mid BL8 and start-over-stop priority
    cyc(1, 8'h40, 3, 0, 1, 0, "R8");
    run(2, "R8");
    cyc(0, 0, 0, 0, 1, 1, "R8");
    cyc(1, 8'h91, 3, 1, 1, 0, "R8");
    run(2, "R8");
    cyc(1, 8'h22, 2, 0, 0, 1, "R8");
    run(2, "R8");
    // R1 restart in mid burst
    cyc(1, 8'hC6, 2, 1, 1, 0, "R1");
    run(5, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no end, expected end of run");
      finishRun();
    end
  end

endmodule